// File: doc/BRIEF.md
# Reloadable Fail-Safe Watchdog Timer

This block watches over software. A 16-bit counter counts up on a clock taken from the system clock through a prescaler with four settings. Software must restart it with a service strobe. The strobe places an 8-bit reload value in the upper byte of the counter and zeroes the lower byte, so that value sets how long software has before the next strobe is due. If the counter runs past its all-ones value first, the block raises a one-cycle internal reset request. It also holds an active-low reset line low for a fixed number of clocks, so that parts outside the chip can be reset with it.

The watchdog comes out of every reset already running, so start-up is always covered. A mode input chooses the lock rules. In compatible mode, software may switch the watchdog off only until it signals the end of initialisation. In enhanced mode it may switch it off and on again at any time.

Top module: `wdt_top`

## Requirements
- R1: After reset, resetOutN is 1, resetReq is 0, the counter is 0x0000, the watchdog is enabled and the end-of-init lock is clear. An overflow therefore happens without any enable strobe.
- R2: prescSel picks the count clock: code 0 divides the system clock by 2, code 1 by 4, code 2 by 128 and code 3 by 256. The prescaler restarts from zero on each service strobe.
- R3: A service strobe sets the counter to {reloadVal, 8'h00} on the next clock edge.
- R4: After a service strobe at edge E0 with reload value R and divisor D, the counter steps past 0xFFFF at edge E0 + D*(65536 - 256*R). resetOutN goes low right after that edge.
- R5: On overflow, resetReq is high for exactly one cycle and resetOutN is low for exactly 16 cycles. During those 16 cycles the counter is held at zero. Once they end, enable is set and the end-of-init lock is clear again.
- R6: With enhancedMode = 0, a disable strobe takes effect only if no end-of-init strobe has come since the last reset. Enable strobes are ignored in this mode.
- R7: With enhancedMode = 1, disable and enable strobes take effect at any time. If both arrive in the same cycle, enable wins.
- R8: A service strobe in the cycle where the counter would overflow wins: no reset request follows, and the counter reloads.
- R9: While the watchdog is disabled, the counter holds its value and no overflow happens. A service strobe still reloads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serviceStb | input | 1 | Service strobe from software |
| reloadVal | input | 8 | Reload value for the counter's upper byte |
| prescSel | input | 2 | Prescaler select code |
| disableStb | input | 1 | Request to stop the watchdog |
| enableStb | input | 1 | Request to restart the watchdog |
| initDoneStb | input | 1 | End-of-initialisation strobe |
| enhancedMode | input | 1 | 0 = compatible lock rules, 1 = enhanced |
| resetReq | output | 1 | One-cycle internal reset request |
| resetOutN | output | 1 | Active-low reset line for external devices |

## Verification
The hardest case to reach is a service strobe that lands in the one cycle where the counter sits at 0xFFFF and a prescaler tick is due. Only there does the priority rule decide between a reload and a reset. The bench reaches it without looking inside the design. It services with reload 0xFF at divide-by-2, counts 511 cycles from the service edge, and strobes again in the next cycle. A cycle-level reference model, driven by seeded random strobes and modes, then covers the same race and the lock rules at points no directed test picks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;  // counter may advance on a prescaler tick
    logic hold;     // reset pulse active: clear counter and prescaler
  } wdtCtl_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRESC_W = 8,
  parameter int DIV_EXP0 = 1,
  parameter int DIV_EXP1 = 2,
  parameter int DIV_EXP2 = 7,
  parameter int DIV_EXP3 = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam logic [PRESC_W-1:0] MASK0 = PRESC_W'((1 << DIV_EXP0) - 1);
  localparam logic [PRESC_W-1:0] MASK1 = PRESC_W'((1 << DIV_EXP1) - 1);
  localparam logic [PRESC_W-1:0] MASK2 = PRESC_W'((1 << DIV_EXP2) - 1);
  localparam logic [PRESC_W-1:0] MASK3 = PRESC_W'((1 << DIV_EXP3) - 1);

  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] mask;

  always_comb begin
    case (sel)
      2'd0:    mask = MASK0;
      2'd1:    mask = MASK1;
      2'd2:    mask = MASK2;
      default: mask = MASK3;
    endcase
  end

  assign tick = ((presc & mask) == mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      presc <= '0;
    else if (clear) presc <= '0;
    else            presc <= presc + 1'b1;
  end

  // Every divisor is at least 2, so two ticks never come back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !clear) |=> !tick);
  // A restart puts the prescaler at zero, and no divisor ticks at zero
  assert_clear_restarts_R2: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !tick);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RELOAD_W = 8,
  parameter int PRESC_W  = 8,
  parameter int DIV_EXP0 = 1,
  parameter int DIV_EXP1 = 2,
  parameter int DIV_EXP2 = 7,
  parameter int DIV_EXP3 = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdtCtl_t             ctl,
  input  logic                serviceStb,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic [1:0]          prescSel,
  output logic                wrapEvt
);
  localparam int LOW_W = CNT_W - RELOAD_W;

  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             atMax;

  wdt_prescaler #(
    .PRESC_W(PRESC_W), .DIV_EXP0(DIV_EXP0), .DIV_EXP1(DIV_EXP1),
    .DIV_EXP2(DIV_EXP2), .DIV_EXP3(DIV_EXP3)
  ) uPresc (
    .clk(clk), .rstN(rstN), .clear(ctl.hold | serviceStb),
    .sel(prescSel), .tick(tick)
  );

  assign atMax   = &cnt;
  assign wrapEvt = !ctl.hold && !serviceStb && ctl.countEn && tick && atMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (ctl.hold)              cnt <= '0;
    else if (serviceStb)            cnt <= {reloadVal, {LOW_W{1'b0}}};
    else if (ctl.countEn && tick)   cnt <= cnt + 1'b1;
  end

  assert_service_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (serviceStb && !ctl.hold) |=> (cnt == {$past(reloadVal), {LOW_W{1'b0}}}));
  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> (cnt == '0));
  assert_disabled_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.countEn && !serviceStb && !ctl.hold) |=> $stable(cnt));
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrapEvt,
  input  logic    disableStb,
  input  logic    enableStb,
  input  logic    initDoneStb,
  input  logic    enhancedMode,
  output wdtCtl_t ctl,
  output logic    resetReq,
  output logic    resetOutN
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          enabled;
  logic          initDone;
  logic [PW-1:0] pulseCnt;
  logic          reqQ;
  logic          pulseActive;

  assign pulseActive = (pulseCnt != '0);
  assign ctl.hold    = pulseActive;
  assign ctl.countEn = enabled && !pulseActive;
  assign resetReq    = reqQ;
  assign resetOutN   = !pulseActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      reqQ     <= 1'b0;
    end else if (wrapEvt) begin
      pulseCnt <= PW'(PULSE_LEN);
      reqQ     <= 1'b1;
    end else begin
      reqQ <= 1'b0;
      if (pulseActive) pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled  <= 1'b1;
      initDone <= 1'b0;
    end else if (pulseActive) begin
      enabled  <= 1'b1;
      initDone <= 1'b0;
    end else begin
      if (initDoneStb) initDone <= 1'b1;
      if (enableStb && enhancedMode)                        enabled <= 1'b1;
      else if (disableStb && (enhancedMode || !initDone))   enabled <= 1'b0;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (resetOutN && !resetReq && enabled && !initDone));
  assert_req_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  assert_req_with_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !resetOutN);
  assert_compat_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!enhancedMode && initDone && enabled) |=> enabled);
  assert_enh_disable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enhancedMode && disableStb && !enableStb && !pulseActive) |=> !enabled);
  assert_enh_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enhancedMode && enableStb) |=> enabled);
  assert_no_wrap_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> !resetReq);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int RELOAD_W  = 8,
  parameter int PRESC_W   = 8,
  parameter int DIV_EXP0  = 1,
  parameter int DIV_EXP1  = 2,
  parameter int DIV_EXP2  = 7,
  parameter int DIV_EXP3  = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serviceStb,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic [1:0]          prescSel,
  input  logic                disableStb,
  input  logic                enableStb,
  input  logic                initDoneStb,
  input  logic                enhancedMode,
  output logic                resetReq,
  output logic                resetOutN
);
  wdtCtl_t ctl;
  logic    wrapEvt;

  wdt_datapath #(
    .CNT_W(CNT_W), .RELOAD_W(RELOAD_W), .PRESC_W(PRESC_W),
    .DIV_EXP0(DIV_EXP0), .DIV_EXP1(DIV_EXP1),
    .DIV_EXP2(DIV_EXP2), .DIV_EXP3(DIV_EXP3)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .serviceStb(serviceStb),
    .reloadVal(reloadVal), .prescSel(prescSel), .wrapEvt(wrapEvt)
  );

  wdt_control #(.PULSE_LEN(PULSE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .wrapEvt(wrapEvt), .disableStb(disableStb),
    .enableStb(enableStb), .initDoneStb(initDoneStb),
    .enhancedMode(enhancedMode), .ctl(ctl), .resetReq(resetReq),
    .resetOutN(resetOutN)
  );

  // Service wins over a wrap in the same cycle
  assert_service_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (serviceStb && resetOutN) |=> !resetReq);
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       svc = 1'b0, dis = 1'b0, en = 1'b0, initS = 1'b0, enh = 1'b0;
  logic [7:0] reloadV = 8'h00;
  logic [1:0] sel = 2'd0;
  logic       resetReq, resetOutN;

  int checks = 0, failures = 0, cycles = 0;
  bit cmpOn = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  wdt_top dut (
    .clk(clk), .rstN(rstN), .serviceStb(svc), .reloadVal(reloadV),
    .prescSel(sel), .disableStb(dis), .enableStb(en), .initDoneStb(initS),
    .enhancedMode(enh), .resetReq(resetReq), .resetOutN(resetOutN)
  );

  function automatic int divOf(input logic [1:0] s);
    case (s)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 128;
      default: return 256;
    endcase
  endfunction

  function automatic int expInterval(input logic [1:0] s, input logic [7:0] r);
    return divOf(s) * (65536 - 256 * int'(r));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-level reference model built from the requirements
  logic [15:0] mCnt;
  logic [7:0]  mPresc;
  logic        mEn, mInit, mReq;
  int          mPulse;

  always @(posedge clk or negedge rstN) begin : refModel
    logic hold, tick, wrap;
    logic [7:0] mask;
    if (!rstN) begin
      mCnt <= '0; mPresc <= '0; mEn <= 1'b1; mInit <= 1'b0;
      mReq <= 1'b0; mPulse <= 0;
    end else begin
      hold = (mPulse != 0);
      mask = 8'(divOf(sel) - 1);
      tick = ((mPresc & mask) == mask);
      wrap = !hold && !svc && mEn && tick && (mCnt == 16'hFFFF);
      mPresc <= (hold || svc) ? 8'h00 : mPresc + 8'd1;
      if (hold) mCnt <= '0;
      else if (svc) mCnt <= {reloadV, 8'h00};
      else if (mEn && tick) mCnt <= mCnt + 16'd1;
      if (wrap) begin mPulse <= 16; mReq <= 1'b1; end
      else begin mReq <= 1'b0; if (hold) mPulse <= mPulse - 1; end
      if (hold) begin mEn <= 1'b1; mInit <= 1'b0; end
      else begin
        if (initS) mInit <= 1'b1;
        if (en && enh) mEn <= 1'b1;
        else if (dis && (enh || !mInit)) mEn <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn && !done)
      chk(resetOutN == (mPulse == 0) && resetReq == mReq,
          "R5/R7 model compare", {resetOutN, resetReq}, {(mPulse == 0), mReq});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic doReset();
    rstN = 1'b0; svc = 0; dis = 0; en = 0; initS = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic service(input logic [7:0] r, input logic [1:0] s);
    reloadV = r; sel = s; svc = 1'b1;
    @(negedge clk);
    svc = 1'b0;
  endtask

  task automatic strobe(input int which);
    case (which)
      0: dis = 1'b1;
      1: en = 1'b1;
      2: initS = 1'b1;
      default: begin dis = 1'b1; en = 1'b1; end
    endcase
    @(negedge clk);
    dis = 0; en = 0; initS = 0;
  endtask

  task automatic waitLow(input int limit, output int m);
    m = 0;
    while (resetOutN && m < limit) begin
      @(negedge clk);
      m++;
    end
  endtask

  task automatic pulseCheck();
    int w = 0;
    chk(resetReq == 1'b1, "R5 request at overflow", resetReq, 1);
    while (!resetOutN && w < 100) begin
      w++;
      @(negedge clk);
      if (w == 1) chk(resetReq == 1'b0, "R5 request one cycle", resetReq, 0);
    end
    chk(w == 16, "R5 low width", w, 16);
  endtask

  initial begin
    int m;
    void'($urandom(32'h5eed_0017));
    doReset();
    cmpOn = 1'b1;
    chk(resetOutN && !resetReq, "R1 reset outputs", {resetOutN, resetReq}, 2);

    // R4 / R2 intervals across all divisor codes; R1: running with no enable
    service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == expInterval(2'd0, 8'hFF), "R4 R1 div2 reload FF", m, expInterval(2'd0, 8'hFF));
    pulseCheck();
    service(8'hFE, 2'd1); waitLow(3000, m);
    chk(m == expInterval(2'd1, 8'hFE), "R2 div4 reload FE", m, expInterval(2'd1, 8'hFE));
    pulseCheck();
    service(8'hFF, 2'd2); waitLow(40000, m);
    chk(m == expInterval(2'd2, 8'hFF), "R2 div128", m, expInterval(2'd2, 8'hFF));
    pulseCheck();
    service(8'hFF, 2'd3); waitLow(70000, m);
    chk(m == expInterval(2'd3, 8'hFF), "R2 div256", m, expInterval(2'd3, 8'hFF));
    pulseCheck();

    // R8: service lands on the wrap cycle
    service(8'hFF, 2'd0);
    repeat (511) @(negedge clk);
    svc = 1'b1; @(negedge clk); svc = 1'b0;
    chk(resetOutN && !resetReq, "R8 no reset on race", {resetOutN, resetReq}, 2);
    waitLow(600, m);
    chk(m == 512, "R8 R3 reload after race", m, 512);
    pulseCheck();

    // R6 compatible mode
    doReset(); enh = 1'b0;
    strobe(0); service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == 600, "R6 disable before init", m, 600);
    strobe(1); service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == 600, "R6 enable ignored", m, 600);
    doReset();
    strobe(2); strobe(0); service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == 512, "R6 disable locked", m, 512);
    pulseCheck();
    strobe(0); service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == 600, "R5 lock cleared after pulse", m, 600);

    // R7 enhanced mode
    doReset(); enh = 1'b1;
    strobe(2); strobe(0); service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == 600, "R7 disable after init", m, 600);
    strobe(1); service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == 512, "R7 enable", m, 512);
    pulseCheck();
    strobe(3); service(8'hFF, 2'd0); waitLow(600, m);
    chk(m == 512, "R7 enable wins", m, 512);
    pulseCheck();

    // R9 service while disabled
    doReset(); enh = 1'b1;
    strobe(0); service(8'hFF, 2'd0);
    repeat (50) @(negedge clk);
    chk(resetOutN, "R9 no overflow disabled", resetOutN, 1);
    strobe(1); waitLow(1000, m);
    chk(m >= 508 && m <= 514, "R9 reload kept while disabled", m, 512);
    pulseCheck();

    // Seeded random traffic checked by the model
    doReset();
    for (int i = 0; i < 20000; i++) begin
      svc   = ($urandom_range(0, 1499) == 0);
      dis   = ($urandom_range(0, 255) == 0);
      en    = ($urandom_range(0, 255) == 0);
      initS = ($urandom_range(0, 511) == 0);
      if ($urandom_range(0, 1023) == 0) enh = ~enh;
      reloadV = 8'($urandom_range(240, 255));
      sel = 2'($urandom_range(0, 1));
      @(negedge clk);
    end
    svc = 0; dis = 0; en = 0; initS = 0;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule